// File: doc/BRIEF.md
# Dual-Rail Precharged Boolean Operator

This block evaluates one two-input Boolean function on operands held in dual-rail form. Each operand arrives as an 8-bit word. Only its two lowest bits matter, and they carry a single logical bit as a rail pair: `01` means logical 1, `10` means logical 0, and `00` is the empty (precharged) code. The block never computes the function with gates. It joins the two rail pairs into a 4-bit index and reads the answer from a 16-entry table of 2-bit codes.

All the work runs as a fixed chain of thirteen single-cycle micro-steps over three working registers and a result register. Every register is forced to zero before it takes a new value. As a result, each step switches a number of bits that does not depend on the data. The steps are, in order:

1. clear the first register;
2. load the first operand into it;
3. mask it to its code bits;
4. shift it left by one;
5. shift it left by one again;
6. clear the second register;
7. load the second operand into it;
8. mask it to its code bits;
9. merge the two registers with OR;
10. clear the third register;
11. look up the table into the third register;
12. clear the result register;
13. write the result register.

A caller pulses `start`, keeps the operands and the operator select steady while `busy` is high, and reads `result` when `done` pulses. Results come out in the same encoding, so one invocation can feed the next.

Top module: `dr_op_seq`

## Requirements
- R1: Only bits [1:0] of each operand are used. Bits [7:2] have no effect on `result` or `code_err`. Code `01` is logical 1 and `10` is logical 0.
- R2: A start that is accepted while idle raises `busy` on the next clock edge. Exactly 13 edges after the accepting edge, `done` goes high for one cycle and `busy` falls at the same edge.
- R3: A `start` pulse that arrives while `busy` is high is ignored. The run in progress keeps its timing and its result.
- R4: `op_sel` selects the operator: `00` is AND, `01` is OR, `10` is XOR. The output is `01` for a true result and `10` for a false one.
- R5: With `op_sel` = `11`, the result is the entry of the programmable table at index {a code, b code}. The a code sits in bits [3:2] of the index and the b code in bits [1:0].
- R6: A table write (`tbl_we`, `tbl_addr`, `tbl_wdata`) takes effect only while `busy` is low. A write made while busy changes nothing.
- R7: If either operand code is `00` or `11`, `code_err` is high when `done` pulses. With a preset operator, `result` is then `00`.
- R8: `result` reads zero in the cycle just before `done`. Its bits [7:2] are always zero, and any change of `result` either goes to zero or starts from zero.
- R9: After reset, `busy`, `done`, `code_err` and `result` are zero, and every entry of the programmable table is `00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one evaluation when idle |
| opnd_a | input | 8 | First operand word, rail pair in bits [1:0] |
| opnd_b | input | 8 | Second operand word, rail pair in bits [1:0] |
| op_sel | input | 2 | Operator select: AND, OR, XOR or programmable table |
| tbl_we | input | 1 | Write enable for the programmable table |
| tbl_addr | input | 4 | Programmable table entry index |
| tbl_wdata | input | 2 | Code written into the entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| result | output | 8 | Encoded result, code in bits [1:0] |
| code_err | output | 1 | An operand carried an invalid code |

## Verification
Two things can land on the same clock edge while a run is in flight: a fresh `start`, and a write to the programmable table. The bench raises both together in the fourth cycle of a run. The write targets the very entry that a later programmable-table run will read. The bench then judges three things: the disturbed run must still finish on edge 13 with its own result and a zero precharge cycle in front of it, and the later lookup must return the value written while idle, not the value written while busy.

// File: rtl/dr_op_pkg.sv
package dr_op_pkg;

  localparam int CODE_W   = 2;
  localparam int IDX_W    = 2 * CODE_W;
  localparam int TBL_DEPTH = 1 << IDX_W;

  typedef enum logic [3:0] {
    ST_CLR_R1  = 4'd0,
    ST_LD_A    = 4'd1,
    ST_MSK_A   = 4'd2,
    ST_SHL_1   = 4'd3,
    ST_SHL_2   = 4'd4,
    ST_CLR_R2  = 4'd5,
    ST_LD_B    = 4'd6,
    ST_MSK_B   = 4'd7,
    ST_MERGE   = 4'd8,
    ST_CLR_R3  = 4'd9,
    ST_LOOKUP  = 4'd10,
    ST_CLR_D   = 4'd11,
    ST_WR_D    = 4'd12
  } step_e;

  localparam step_e LAST_STEP = ST_WR_D;

  localparam logic [1:0] OPS_AND  = 2'b00;
  localparam logic [1:0] OPS_OR   = 2'b01;
  localparam logic [1:0] OPS_XOR  = 2'b10;
  localparam logic [1:0] OPS_PROG = 2'b11;

  localparam logic [CODE_W-1:0] CODE_ONE  = 2'b01;
  localparam logic [CODE_W-1:0] CODE_ZERO = 2'b10;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c == CODE_ONE) || (c == CODE_ZERO);
  endfunction

  // Preset table entry for a fixed operator; invalid index pairs give 00.
  function automatic logic [CODE_W-1:0] preset_code(input logic [1:0] sel,
                                                    input logic [IDX_W-1:0] idx);
    logic [CODE_W-1:0] ca, cb;
    logic la, lb, r;
    ca = idx[IDX_W-1:CODE_W];
    cb = idx[CODE_W-1:0];
    la = (ca == CODE_ONE);
    lb = (cb == CODE_ONE);
    case (sel)
      OPS_AND: r = la & lb;
      OPS_OR:  r = la | lb;
      default: r = la ^ lb;
    endcase
    if (!code_ok(ca) || !code_ok(cb)) return '0;
    return r ? CODE_ONE : CODE_ZERO;
  endfunction

endpackage

// File: rtl/dr_op_ctrl.sv
module dr_op_ctrl
  import dr_op_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output logic  busy,
  output logic  done,
  output step_e step
);

  step_e step_q, step_n;
  logic  busy_q, busy_n;
  logic  done_q, done_n;

  always_comb begin
    step_n = step_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        step_n = ST_CLR_R1;
      end
    end else if (step_q == LAST_STEP) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      step_n = ST_CLR_R1;
    end else begin
      step_n = step_e'(step_q + 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_CLR_R1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign step = step_q;

endmodule

// File: rtl/dr_op_table.sv
module dr_op_table
  import dr_op_pkg::*;
#(
  parameter int DEPTH = TBL_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [1:0]        sel,
  input  logic [IDX_W-1:0]  raddr,
  output logic [CODE_W-1:0] rdata
);

  logic [CODE_W-1:0] mem_q [DEPTH];
  logic [CODE_W-1:0] mem_n [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_n[i] = mem_q[i];
      if (we && (waddr == IDX_W'(i))) mem_n[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  always_comb begin
    if (sel == OPS_PROG) rdata = mem_q[raddr];
    else                 rdata = preset_code(sel, raddr);
  end

endmodule

// File: rtl/dr_op_seq.sv
module dr_op_seq
  import dr_op_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [1:0]        op_sel,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [CODE_W-1:0] tbl_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              code_err
);

  localparam logic [WORD_W-1:0] CODE_MASK = WORD_W'((1 << CODE_W) - 1);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  step_e             step;
  logic              seq_busy, seq_done;
  logic [CODE_W-1:0] tbl_rdata;

  logic [WORD_W-1:0] r1_q, r1_n, r2_q, r2_n, r3_q, r3_n, d_q, d_n;
  logic              err_q, err_n, cerr_q, cerr_n;

  dr_op_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .busy  (seq_busy),
    .done  (seq_done),
    .step  (step)
  );

  dr_op_table u_tbl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (tbl_we & ~seq_busy),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .sel   (op_sel),
    .raddr (r1_q[IDX_W-1:0]),
    .rdata (tbl_rdata)
  );

  always_comb begin
    r1_n   = r1_q;
    r2_n   = r2_q;
    r3_n   = r3_q;
    d_n    = d_q;
    err_n  = err_q;
    cerr_n = cerr_q;
    if (seq_busy) begin
      case (step)
        ST_CLR_R1: r1_n = '0;
        ST_LD_A:   r1_n = opnd_a;
        ST_MSK_A:  r1_n = r1_q & CODE_MASK;
        ST_SHL_1,
        ST_SHL_2:  r1_n = r1_q << 1;
        ST_CLR_R2: r2_n = '0;
        ST_LD_B:   r2_n = opnd_b;
        ST_MSK_B:  r2_n = r2_q & CODE_MASK;
        ST_MERGE: begin
          r1_n  = r1_q | r2_q;
          err_n = !code_ok(r1_q[IDX_W-1:CODE_W]) || !code_ok(r2_q[CODE_W-1:0]);
        end
        ST_CLR_R3: r3_n = '0;
        ST_LOOKUP: r3_n = {{(WORD_W-CODE_W){1'b0}}, tbl_rdata};
        ST_CLR_D:  d_n  = '0;
        ST_WR_D: begin
          d_n    = r3_q;
          cerr_n = err_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      r1_q   <= '0;
      r2_q   <= '0;
      r3_q   <= '0;
      d_q    <= '0;
      err_q  <= 1'b0;
      cerr_q <= 1'b0;
    end else if (seq_busy) begin
      r1_q   <= r1_n;
      r2_q   <= r2_n;
      r3_q   <= r3_n;
      d_q    <= d_n;
      err_q  <= err_n;
      cerr_q <= cerr_n;
    end
  end

  assign busy     = seq_busy;
  assign done     = seq_done;
  assign result   = d_q;
  assign code_err = cerr_q;

endmodule

// File: rtl/dr_op_seq_chk.sv
module dr_op_seq_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] result,
  input logic              code_err,
  input logic [1:0]        op_sel
);

  logic [4:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 5'd1;
    else           run_cnt <= '0;
  end

  // R2: done only on the 13th edge after acceptance
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 5'd13 && !busy));

  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: invalid code with a preset operator yields the empty code
  p_err_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && code_err && op_sel != 2'b11) |-> (result == '0));

  // R4: a valid preset evaluation gives a valid code
  p_valid_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !code_err && op_sel != 2'b11) |->
      (result[1:0] == 2'b01 || result[1:0] == 2'b10));

  // R8: upper result bits stay clear
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result[WORD_W-1:2] == '0);

  // R8: every change of result passes through zero
  p_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (result == '0 || $past(result) == '0));

endmodule

bind dr_op_seq dr_op_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .code_err (code_err),
  .op_sel   (op_sel)
);

// File: tb/dr_op_seq_test.sv
`timescale 1ns/1ps
module dr_op_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] opnd_a, opnd_b;
  logic [1:0] op_sel;
  logic       tbl_we;
  logic [3:0] tbl_addr;
  logic [1:0] tbl_wdata;
  logic       busy, done, code_err;
  logic [7:0] result;

  always #2.5 clk = ~clk;

  dr_op_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_sel(op_sel), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .busy(busy), .done(done), .result(result), .code_err(code_err)
  );

  typedef struct {
    logic [7:0] res;
    logic       err;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         failures = 0;
  logic [1:0] prog_mirror [16];
  bit         finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                 input logic [1:0] s, input string tag);
    exp_t e;
    logic [1:0] ca, cb;
    bit va, vb, r;
    ca = a[1:0]; cb = b[1:0];
    va = (ca == 2'b01) || (ca == 2'b10);
    vb = (cb == 2'b01) || (cb == 2'b10);
    e.tag = tag;
    e.err = !(va && vb);
    if (s == 2'b11) e.res = {6'b0, prog_mirror[{ca, cb}]};
    else if (!(va && vb)) e.res = 8'h00;
    else begin
      case (s)
        2'b00:   r = (ca == 2'b01) && (cb == 2'b01);
        2'b01:   r = (ca == 2'b01) || (cb == 2'b01);
        default: r = (ca == 2'b01) != (cb == 2'b01);
      endcase
      e.res = r ? 8'h01 : 8'h02;
    end
    return e;
  endfunction

  // Monitor: pops expected items as done pulses
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected done", 32'(done), 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res, {e.tag, " result"}, 32'(result), 32'(e.res));
        check(code_err == e.err, {e.tag, " code_err"}, 32'(code_err), 32'(e.err));
      end
    end
  end

  task automatic tbl_write(input logic [3:0] addr, input logic [1:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = addr; tbl_wdata = data;
    @(negedge clk);
    tbl_we = 1'b0;
    prog_mirror[addr] = data;
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [1:0] s,
                        input string tag, input bit disturb);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = s; start = 1'b1;
    sb.push_back(model(a, b, s, tag));
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'h1);
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      if (disturb && k == 3) begin
        start = 1'b1; tbl_we = 1'b1; tbl_addr = 4'd5; tbl_wdata = 2'b11;
      end
      if (disturb && k == 4) begin
        start = 1'b0; tbl_we = 1'b0;
      end
      if (k == 12)
        check(result == 8'h00 && done == 1'b0, "R8 precharge before done",
              32'({done, result}), 32'h0);
      if (k == 13)
        check(done == 1'b1 && busy == 1'b0, "R2 done at edge 13",
              32'({done, busy}), 32'h2);
    end
    @(negedge clk);
    check(done == 1'b0, "R2 done single pulse", 32'(done), 32'h0);
    check(busy == 1'b0, "R3 no restart from ignored start", 32'(busy), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) prog_mirror[i] = 2'b00;
    rst_n = 1'b0; start = 1'b0; opnd_a = '0; opnd_b = '0; op_sel = '0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check(busy == 1'b0, "R9 busy", 32'(busy), 32'h0);
    check(done == 1'b0, "R9 done", 32'(done), 32'h0);
    check(result == 8'h00, "R9 result", 32'(result), 32'h0);
    check(code_err == 1'b0, "R9 code_err", 32'(code_err), 32'h0);
    // R9 programmable table empty after reset
    run_op(8'h01, 8'h01, 2'b11, "R9 table cleared", 0);

    // R4 presets over all valid combinations
    for (int s = 0; s < 3; s++)
      for (int ia = 0; ia < 2; ia++)
        for (int ib = 0; ib < 2; ib++)
          run_op(ia ? 8'h01 : 8'h02, ib ? 8'h01 : 8'h02, 2'(s), "R4 preset", 0);

    // R1 upper operand bits ignored
    run_op(8'hA5, 8'h7E, 2'b00, "R1 upper bits", 0);
    run_op(8'hFD, 8'h02, 2'b10, "R1 upper bits xor", 0);

    // R7 invalid codes
    run_op(8'h00, 8'h01, 2'b01, "R7 empty a", 0);
    run_op(8'h01, 8'h03, 2'b00, "R7 bad b", 0);
    run_op(8'h03, 8'h02, 2'b10, "R7 bad a", 0);

    // R5 programmable table (NAND)
    tbl_write(4'd5, 2'b10);
    tbl_write(4'd6, 2'b01);
    tbl_write(4'd9, 2'b01);
    tbl_write(4'd10, 2'b01);
    run_op(8'h01, 8'h01, 2'b11, "R5 prog 1,1", 0);
    run_op(8'h01, 8'h02, 2'b11, "R5 prog 1,0", 0);
    run_op(8'h02, 8'h02, 2'b11, "R5 prog 0,0", 0);

    // R3 and R6: start and table write during a run
    run_op(8'h02, 8'h01, 2'b00, "R3 start while busy", 1);
    run_op(8'h01, 8'h01, 2'b11, "R6 write while busy ignored", 0);

    // chained: output of one run as input of the next
    run_op(8'h01, 8'h02, 2'b01, "R4 chain first", 0);
    run_op(result, 8'h01, 2'b00, "R4 chain second", 0);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all results seen", 32'(sb.size()), 32'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule